// File: doc/BRIEF.md
# Shared-Page Directory State Engine

This block keeps the global coherence record for a fixed set of shared pages that a small group of processors uses. Each page has a record with four parts: a mask of the processors that read it, a mask of the processors that write it, a system-wide page state, and a sticky "unsafe" flag. The page state describes the whole machine. It is not the view of any one node. Processors send four kinds of request: read fault, write fault, release-time dirty report and self-invalidate. The engine serves one request at a time, so every update to a record is atomic.

A page can move into the Weak state, which means several users and at least one writer. When that happens to a page that is not flagged unsafe, the engine sends one write notice to every other user of the page. Each notice goes out on a valid/ready output and names the target processor and the page. When one such transition needs more notices than a configured threshold, the page is flagged unsafe. After that, later moves of that page into Weak update the state only and send no notices.

The block finishes each request with a one-cycle done pulse on the requester's line. Along with that pulse it returns the resulting record of the page, so the requester sees the outcome of its own request.

Top module: `page_dir_engine`

## Requirements
- R1: After reset every page record is empty: both masks are zero, the state is Uncached (code 0) and the unsafe flag is clear. No notice and no done pulse is active.
- R2: A read fault (op code 0) adds the requester to the reader mask. A page whose users (readers OR writers) include no writer has state Shared (code 1).
- R3: A write fault (op code 1) adds the requester to the writer mask. A page with exactly one user, who is a writer, has state Dirty (code 2).
- R4: A page with two or more users, at least one of them a writer, has state Weak (code 3).
- R5: When a request moves a page that is not unsafe from a state other than Weak into Weak, the engine sends one notice to each user except the requester. Each notice carries the page number. Notices go out in ascending processor id. No notice ever names the requester.
- R6: A move into Weak that needs more than UNSAFE_THRESH notices sets the page's unsafe flag, and the notices for that move are still sent. Once set, the flag stays set. A later move of that page into Weak sends no notices.
- R7: A release-time dirty report (op code 2) acts as a write fault and sets the requester's processed bit for that page. While the bit is set, further reports from that requester leave the record unchanged and send no notices.
- R8: A self-invalidate (op code 3) removes the requester from both masks and clears its processed bit. The state is then recomputed, and it becomes Uncached when no user remains.
- R9: Requests are granted one at a time in round-robin order, starting after the last granted processor. Each granted request gets exactly one done pulse. The pulse arrives together with the page's resulting record on the response outputs.
- R10: While notice_ready is low, a pending notice holds its processor and page unchanged. The done pulse comes only after every notice of the request has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPROC | Request pending, one bit per processor, held until done |
| req_op | input | 2*NPROC | Request code per processor (0 read, 1 write, 2 release report, 3 invalidate) |
| req_page | input | PW*NPROC | Page number per processor |
| done | output | NPROC | One-cycle completion pulse for the served processor |
| rsp_state | output | 2 | Resulting page state, valid with done |
| rsp_readers | output | NPROC | Resulting reader mask, valid with done |
| rsp_writers | output | NPROC | Resulting writer mask, valid with done |
| rsp_unsafe | output | 1 | Resulting unsafe flag, valid with done |
| notice_valid | output | 1 | A write notice is offered |
| notice_ready | input | 1 | Consumer accepts the offered notice |
| notice_proc | output | IDW | Processor to be notified |
| notice_page | output | PW | Page named by the notice |

## Verification
The assertions assume that a processor holds its request valid, with a stable op code and page, from the time it raises the request until it sees its done pulse, and that it drops the request right after that pulse. They also assume that page numbers stay below NPAGE. The stimulus keeps to these rules in every test. Each request is issued at a falling edge and released at the falling edge where its done pulse is sampled. Only legal page numbers are used, and notice_ready may go low but never keeps a notice waiting forever.

// File: rtl/page_dir_pkg.sv
package page_dir_pkg;

    typedef enum logic [1:0] {
        PG_UNCACHED = 2'd0,
        PG_SHARED   = 2'd1,
        PG_DIRTY    = 2'd2,
        PG_WEAK     = 2'd3
    } pg_state_e;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_RELEASE = 2'd2,
        OP_INVAL   = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_EXEC   = 2'd1,
        ENG_NOTIFY = 2'd2,
        ENG_ACK    = 2'd3
    } eng_state_e;

    // Global page state derived from who uses the page and whether anyone writes it.
    function automatic pg_state_e classify(input logic any_user,
                                           input logic any_writer,
                                           input logic multi_user);
        if (!any_user)        return PG_UNCACHED;
        else if (!any_writer) return PG_SHARED;
        else if (!multi_user) return PG_DIRTY;
        else                  return PG_WEAK;
    endfunction

endpackage

// File: rtl/pd_rr_arbiter.sv
module pd_rr_arbiter #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        for (int k = 0; k < N; k++) begin
            automatic int idx = (int'(ptr) + k) % N;
            if (gnt == '0 && req[idx]) begin
                gnt[idx] = 1'b1;
                gnt_idx  = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (en && (|gnt)) begin
            ptr <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
        end
    end

    // R9: at most one grant, and only to a requester
    p_gnt_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));
    p_gnt_in_req_r9: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

endmodule

// File: rtl/pd_next_entry.sv
module pd_next_entry
    import page_dir_pkg::*;
#(
    parameter int NPROC         = 4,
    parameter int UNSAFE_THRESH = 1,
    localparam int CW = $clog2(NPROC + 1)
) (
    input  req_op_e          op,
    input  logic [NPROC-1:0] me,
    input  logic [NPROC-1:0] old_rd,
    input  logic [NPROC-1:0] old_wr,
    input  pg_state_e        old_st,
    input  logic             old_unsafe,
    input  logic             old_done_bit,
    output logic [NPROC-1:0] new_rd,
    output logic [NPROC-1:0] new_wr,
    output pg_state_e        new_st,
    output logic             new_unsafe,
    output logic             new_done_bit,
    output logic [NPROC-1:0] notice_mask
);
    logic [NPROC-1:0] users;
    logic [NPROC-1:0] others;
    logic [CW-1:0]    n_others;
    logic             into_weak;

    always_comb begin
        new_rd       = old_rd;
        new_wr       = old_wr;
        new_done_bit = old_done_bit;
        unique case (op)
            OP_READ:  new_rd = old_rd | me;
            OP_WRITE: new_wr = old_wr | me;
            OP_RELEASE: begin
                if (!old_done_bit) begin
                    new_wr       = old_wr | me;
                    new_done_bit = 1'b1;
                end
            end
            OP_INVAL: begin
                new_rd       = old_rd & ~me;
                new_wr       = old_wr & ~me;
                new_done_bit = 1'b0;
            end
            default: ;
        endcase

        users    = new_rd | new_wr;
        new_st   = classify(|users, |new_wr, $countones(users) > 1);
        others   = users & ~me;
        n_others = CW'($countones(others));
        into_weak = (new_st == PG_WEAK) && (old_st != PG_WEAK);

        notice_mask = (into_weak && !old_unsafe) ? others : '0;
        new_unsafe  = old_unsafe | (into_weak && (int'(n_others) > UNSAFE_THRESH));
    end

endmodule

// File: rtl/pd_notice_gen.sv
module pd_notice_gen #(
    parameter int NPROC = 4,
    parameter int PW    = 3,
    localparam int IDW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NPROC-1:0] load_mask,
    input  logic [PW-1:0]    load_page,
    input  logic             ready,
    output logic             valid,
    output logic [IDW-1:0]   proc,
    output logic [PW-1:0]    page
);
    logic [NPROC-1:0] pend;

    assign valid = |pend;

    // lowest pending processor goes first
    always_comb begin
        proc = '0;
        for (int k = NPROC - 1; k >= 0; k--) begin
            if (pend[k]) proc = IDW'(k);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            page <= '0;
        end else if (load) begin
            pend <= load_mask;
            page <= load_page;
        end else if (valid && ready) begin
            pend[proc] <= 1'b0;
        end
    end

    // R10: an offered notice is held while the consumer stalls
    p_notice_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready && !load) |=> (valid && $stable(proc) && $stable(page)));

endmodule

// File: rtl/page_dir_engine.sv
module page_dir_engine
    import page_dir_pkg::*;
#(
    parameter int NPROC         = 4,
    parameter int NPAGE         = 8,
    parameter int UNSAFE_THRESH = 1,
    localparam int PW  = (NPAGE > 1) ? $clog2(NPAGE) : 1,
    localparam int IDW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NPROC-1:0]    req_valid,
    input  logic [2*NPROC-1:0]  req_op,
    input  logic [PW*NPROC-1:0] req_page,
    output logic [NPROC-1:0]    done,
    output logic [1:0]          rsp_state,
    output logic [NPROC-1:0]    rsp_readers,
    output logic [NPROC-1:0]    rsp_writers,
    output logic                rsp_unsafe,
    output logic                notice_valid,
    input  logic                notice_ready,
    output logic [IDW-1:0]      notice_proc,
    output logic [PW-1:0]       notice_page
);
    // directory storage
    logic [NPROC-1:0] tb_rd [NPAGE];
    logic [NPROC-1:0] tb_wr [NPAGE];
    logic [NPROC-1:0] tb_pb [NPAGE];
    pg_state_e        tb_st [NPAGE];
    logic             tb_un [NPAGE];

    eng_state_e       eng;
    logic [IDW-1:0]   cur_id;
    req_op_e          cur_op;
    logic [PW-1:0]    cur_page;
    logic [NPROC-1:0] me;

    logic [NPROC-1:0] gnt;
    logic [IDW-1:0]   gnt_idx;

    logic [NPROC-1:0] nx_rd, nx_wr, nx_mask;
    pg_state_e        nx_st;
    logic             nx_un, nx_pb;

    pd_rr_arbiter #(.N(NPROC)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .en      (eng == ENG_IDLE),
        .req     (req_valid),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    always_comb begin
        me         = '0;
        me[cur_id] = 1'b1;
    end

    pd_next_entry #(.NPROC(NPROC), .UNSAFE_THRESH(UNSAFE_THRESH)) u_next (
        .op           (cur_op),
        .me           (me),
        .old_rd       (tb_rd[cur_page]),
        .old_wr       (tb_wr[cur_page]),
        .old_st       (tb_st[cur_page]),
        .old_unsafe   (tb_un[cur_page]),
        .old_done_bit (tb_pb[cur_page][cur_id]),
        .new_rd       (nx_rd),
        .new_wr       (nx_wr),
        .new_st       (nx_st),
        .new_unsafe   (nx_un),
        .new_done_bit (nx_pb),
        .notice_mask  (nx_mask)
    );

    pd_notice_gen #(.NPROC(NPROC), .PW(PW)) u_ntc (
        .clk       (clk),
        .rst       (rst),
        .load      (eng == ENG_EXEC),
        .load_mask (nx_mask),
        .load_page (cur_page),
        .ready     (notice_ready),
        .valid     (notice_valid),
        .proc      (notice_proc),
        .page      (notice_page)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            eng      <= ENG_IDLE;
            cur_id   <= '0;
            cur_op   <= OP_READ;
            cur_page <= '0;
            for (int i = 0; i < NPAGE; i++) begin
                tb_rd[i] <= '0;
                tb_wr[i] <= '0;
                tb_pb[i] <= '0;
                tb_st[i] <= PG_UNCACHED;
                tb_un[i] <= 1'b0;
            end
        end else begin
            unique case (eng)
                ENG_IDLE: begin
                    if (|gnt) begin
                        cur_id   <= gnt_idx;
                        cur_op   <= req_op_e'(req_op[2*gnt_idx +: 2]);
                        cur_page <= req_page[PW*gnt_idx +: PW];
                        eng      <= ENG_EXEC;
                    end
                end
                ENG_EXEC: begin
                    tb_rd[cur_page]         <= nx_rd;
                    tb_wr[cur_page]         <= nx_wr;
                    tb_st[cur_page]         <= nx_st;
                    tb_un[cur_page]         <= nx_un;
                    tb_pb[cur_page][cur_id] <= nx_pb;
                    eng <= (|nx_mask) ? ENG_NOTIFY : ENG_ACK;
                end
                ENG_NOTIFY: begin
                    if (!notice_valid) eng <= ENG_ACK;
                end
                ENG_ACK: eng <= ENG_IDLE;
                default: eng <= ENG_IDLE;
            endcase
        end
    end

    always_comb begin
        done        = '0;
        done[cur_id] = (eng == ENG_ACK);
        rsp_state   = tb_st[cur_page];
        rsp_readers = tb_rd[cur_page];
        rsp_writers = tb_wr[cur_page];
        rsp_unsafe  = tb_un[cur_page];
    end

    // R9: one completion at a time
    p_one_done_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done));
    // R10: completion only once the notice stream has drained
    p_quiet_ack_r10: assert property (@(posedge clk) disable iff (rst)
        (|done) |-> !notice_valid);
    // R5: a requester is never told about its own transition
    p_no_self_notice_r5: assert property (@(posedge clk) disable iff (rst)
        notice_valid |-> (notice_proc != cur_id));
    // R5: notices only appear while the engine is notifying
    p_notice_phase_r5: assert property (@(posedge clk) disable iff (rst)
        notice_valid |-> (eng == ENG_NOTIFY));

    for (genvar g = 0; g < NPAGE; g++) begin : g_sticky
        // R6: the unsafe flag never clears
        p_unsafe_sticky_r6: assert property (@(posedge clk) disable iff (rst)
            tb_un[g] |=> tb_un[g]);
    end

endmodule

// File: tb/page_dir_engine_tb_top.sv
module page_dir_engine_tb_top;

    localparam int NP = 4;
    localparam int NG = 8;
    localparam int PWB = 3;
    localparam int IDB = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [NP-1:0]     req_valid = '0;
    logic [2*NP-1:0]   req_op    = '0;
    logic [PWB*NP-1:0] req_page  = '0;
    logic [NP-1:0]     done;
    logic [1:0]        rsp_state;
    logic [NP-1:0]     rsp_readers, rsp_writers;
    logic              rsp_unsafe;
    logic              notice_valid;
    logic              notice_ready = 1'b1;
    logic [IDB-1:0]    notice_proc;
    logic [PWB-1:0]    notice_page;

    page_dir_engine #(.NPROC(NP), .NPAGE(NG), .UNSAFE_THRESH(1)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_page(req_page),
        .done(done), .rsp_state(rsp_state), .rsp_readers(rsp_readers),
        .rsp_writers(rsp_writers), .rsp_unsafe(rsp_unsafe),
        .notice_valid(notice_valid), .notice_ready(notice_ready),
        .notice_proc(notice_proc), .notice_page(notice_page)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
            $finish;
        end
    end

    typedef struct packed {
        logic [1:0] p;
        logic [1:0] op;
        logic [2:0] pg;
        logic [1:0] st;
        logic [3:0] rd;
        logic [3:0] wr;
        logic       un;
        logic [3:0] nm;
    } vec_t;

    // op: 0 read, 1 write, 2 release report, 3 invalidate
    // st: 0 Uncached, 1 Shared, 2 Dirty, 3 Weak
    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 2'd0, 3'd1, 2'd1, 4'b0001, 4'b0000, 1'b0, 4'b0000},
        '{2'd1, 2'd0, 3'd1, 2'd1, 4'b0011, 4'b0000, 1'b0, 4'b0000},
        '{2'd2, 2'd1, 3'd1, 2'd3, 4'b0011, 4'b0100, 1'b1, 4'b0011},
        '{2'd2, 2'd3, 3'd1, 2'd1, 4'b0011, 4'b0000, 1'b1, 4'b0000},
        '{2'd3, 2'd1, 3'd1, 2'd3, 4'b0011, 4'b1000, 1'b1, 4'b0000},
        '{2'd3, 2'd1, 3'd2, 2'd2, 4'b0000, 4'b1000, 1'b0, 4'b0000},
        '{2'd0, 2'd0, 3'd2, 2'd3, 4'b0001, 4'b1000, 1'b0, 4'b1000},
        '{2'd3, 2'd3, 3'd2, 2'd1, 4'b0001, 4'b0000, 1'b0, 4'b0000},
        '{2'd0, 2'd3, 3'd2, 2'd0, 4'b0000, 4'b0000, 1'b0, 4'b0000},
        '{2'd1, 2'd2, 3'd3, 2'd2, 4'b0000, 4'b0010, 1'b0, 4'b0000},
        '{2'd2, 2'd0, 3'd3, 2'd3, 4'b0100, 4'b0010, 1'b0, 4'b0010},
        '{2'd1, 2'd2, 3'd3, 2'd3, 4'b0100, 4'b0010, 1'b0, 4'b0000},
        '{2'd1, 2'd3, 3'd3, 2'd1, 4'b0100, 4'b0000, 1'b0, 4'b0000},
        '{2'd1, 2'd2, 3'd3, 2'd3, 4'b0100, 4'b0010, 1'b0, 4'b0100},
        '{2'd0, 2'd3, 3'd1, 2'd3, 4'b0010, 4'b1000, 1'b1, 4'b0000}
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 1:          return "R2";
            2, 6:          return "R5";
            4, 14:         return "R6";
            5:             return "R3";
            10:            return "R4";
            9, 11, 13:     return "R7";
            default:       return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic ok,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // results of the last request
    logic [1:0]    r_st;
    logic [NP-1:0] r_rd, r_wr, r_nm;
    logic          r_un, r_order_ok, r_page_ok, r_hold_ok;
    int            r_cnt;

    task automatic do_req(input int p, input int op, input int pg, input int stall);
        int guard;
        int last;
        int left;
        logic [IDB-1:0] held_p;
        logic [PWB-1:0] held_g;
        logic seen;
        r_nm = '0; r_cnt = 0; r_order_ok = 1'b1; r_page_ok = 1'b1; r_hold_ok = 1'b1;
        last = -1; left = stall; seen = 1'b0; held_p = '0; held_g = '0;
        @(negedge clk);
        notice_ready = (stall == 0);
        req_op[2*p +: 2]     = 2'(op);
        req_page[PWB*p +: PWB] = PWB'(pg);
        req_valid[p]         = 1'b1;
        guard = 0;
        forever begin
            @(negedge clk);
            guard++;
            if (notice_valid) begin
                if (!notice_ready) begin
                    if (seen && (notice_proc != held_p || notice_page != held_g))
                        r_hold_ok = 1'b0;
                    seen = 1'b1; held_p = notice_proc; held_g = notice_page;
                    left--;
                    if (left <= 0) notice_ready = 1'b1;
                end
                if (notice_ready) begin
                    r_cnt++;
                    r_nm[notice_proc] = 1'b1;
                    if (int'(notice_proc) <= last) r_order_ok = 1'b0;
                    last = int'(notice_proc);
                    if (int'(notice_page) != pg) r_page_ok = 1'b0;
                end
            end
            if (done[p]) begin
                r_st = rsp_state; r_rd = rsp_readers; r_wr = rsp_writers; r_un = rsp_unsafe;
                req_valid[p] = 1'b0;
                break;
            end
            if (guard > 500) begin
                check("R9", "request never completed", 1'b0, guard, 0);
                req_valid[p] = 1'b0;
                break;
            end
        end
        notice_ready = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: idle outputs after reset
        check("R1", "notice_valid after reset", notice_valid == 1'b0, notice_valid, 0);
        check("R1", "done after reset", done == '0, done, 0);
        // R1: an untouched page reads back empty and Uncached
        do_req(0, 3, 7, 0);
        check("R1", "fresh page record",
              r_st == 2'd0 && r_rd == '0 && r_wr == '0 && r_un == 1'b0,
              {r_st, r_rd, r_wr, r_un}, 0);

        // table walk covering R2..R8
        for (int i = 0; i < NV; i++) begin
            do_req(int'(TBL[i].p), int'(TBL[i].op), int'(TBL[i].pg), 0);
            check(tag_of(i), $sformatf("step %0d record", i),
                  r_st == TBL[i].st && r_rd == TBL[i].rd && r_wr == TBL[i].wr && r_un == TBL[i].un,
                  {r_st, r_rd, r_wr, r_un}, {TBL[i].st, TBL[i].rd, TBL[i].wr, TBL[i].un});
            check(tag_of(i), $sformatf("step %0d notice targets", i),
                  r_nm == TBL[i].nm, r_nm, TBL[i].nm);
            check("R5", $sformatf("step %0d notice order/page", i),
                  r_order_ok && r_page_ok && (r_cnt == $countones(TBL[i].nm)),
                  r_cnt, $countones(TBL[i].nm));
        end

        // R9: three simultaneous requests; pointer sits after processor 0
        begin
            int order [3];
            int n;
            int guard;
            n = 0; guard = 0;
            @(negedge clk);
            req_op   = '0;
            req_page[PWB*0 +: PWB] = 3'd5;
            req_page[PWB*1 +: PWB] = 3'd6;
            req_page[PWB*2 +: PWB] = 3'd7;
            req_valid = 4'b0111;
            while (n < 3 && guard < 500) begin
                @(negedge clk);
                guard++;
                for (int k = 0; k < NP; k++) begin
                    if (done[k]) begin
                        if (n < 3) order[n] = k;
                        n++;
                        req_valid[k] = 1'b0;
                    end
                end
            end
            req_valid = '0;
            check("R9", "all requests served", n == 3, n, 3);
            check("R9", "round-robin order", order[0] == 1 && order[1] == 2 && order[2] == 0,
                  order[0] * 100 + order[1] * 10 + order[2], 120);
        end

        // R10: back-pressure on a three-notice transition (also R6: 3 > threshold)
        do_req(0, 0, 4, 0);
        do_req(1, 0, 4, 0);
        do_req(2, 0, 4, 0);
        check("R2", "three readers Shared", r_st == 2'd1 && r_rd == 4'b0111, {r_st, r_rd}, {2'd1, 4'b0111});
        do_req(3, 1, 4, 5);
        check("R10", "stalled notice held stable", r_hold_ok, r_hold_ok, 1);
        check("R10", "all notices delivered before done", r_cnt == 3 && r_nm == 4'b0111, r_nm, 4'b0111);
        check("R6", "unsafe after wide transition", r_st == 2'd3 && r_un == 1'b1, {r_st, r_un}, {2'd3, 1'b1});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule